// File: doc/BRIEF.md
# Mixed-Decay Chopping Current Controller

This block runs the constant-current chopping loop of one motor phase. A chopping oscillator delivers a one-clock tick per sub-cycle, and four ticks make up one chopping period. Within each period the block drives the bridge first in charge mode until a comparator reports that the sensed current has reached the set point. It then holds slow decay and moves to fast decay at a point in the period tail that the decay select chooses. The set point itself is the phase magnitude scaled by a torque select.

When the current is still above the set point at a period boundary, the next period skips normal charging. The bridge gets only a short probe charge, which is used to re-sample the comparator. A step event makes the chopping counter restart on the next oscillator tick, and that restart also begins with a probe. The comparator is asynchronous, so it is synchronized first, and a reach event is ignored in the first clocks of every charge phase.

Top module: `chop_ctrl`

## Requirements
- R1: After reset the slot counter is 0 and the controller is in charge, so with a nonzero magnitude `mode_o` is 1 (charge). The mode encoding is 0 off, 1 charge, 2 slow decay, 3 fast decay.
- R2: `slot_o` advances by one on each `osc_tick_i` and holds between ticks. A tick while it is 3 wraps it to 0 and starts a new period.
- R3: `setpt_o` = floor(`mag_i` × K / 64), where K is 64, 48, 32 or 13 for `torque_sel_i` equal to 0, 1, 2 or 3 (100 %, 75 %, 50 %, about 20 %).
- R4: `cmp_i` passes through two synchronizer flops, so a change affects the mode at the third rising edge. During the first BLANK_CLKS (default 2) clocks of a charge phase, a reach event is ignored.
- R5: In charge, once a reach is seen, the mode becomes fast if the current slot is in the fast window and slow otherwise. Slow becomes fast when the slot enters the window. Fast holds until the next period start. The window is empty for `decay_sel_i` = 0, slot 3 for 1, and slots 2 and 3 for 2.
- R6: With `decay_sel_i` = 3, every slot is in the fast window. A reach therefore leads directly to fast decay, and slow decay never persists.
- R7: At a period start with the synchronized comparator high, the controller enters a probe. The probe outputs charge for PROBE_CLKS clocks (default 3) and samples the comparator in its last clock. If the comparator is high it moves to the decay chosen by R5, otherwise to charge with blanking.
- R8: A step event takes effect on the next oscillator tick (the same tick if they coincide). At that tick the slot goes to 0 and a probe begins, whatever mode was active. Until that tick the step has no effect.
- R9: With `mag_i` = 0, `mode_o` is 0 (off), and `setpt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | One-clock pulse per chopping sub-cycle |
| step_i | input | 1 | Step event pulse |
| cmp_i | input | 1 | Asynchronous comparator, high when current has reached the set point |
| decay_sel_i | input | 2 | Fast-decay share: 0 none, 1 last slot, 2 last two, 3 all |
| torque_sel_i | input | 2 | Set-point scale select |
| mag_i | input | MAG_W | Phase current magnitude |
| setpt_o | output | MAG_W | Scaled set point for the comparator |
| mode_o | output | 2 | Bridge mode: 0 off, 1 charge, 2 slow, 3 fast |
| slot_o | output | 2 | Sub-cycle index within the chopping period |

## Verification
`setpt_o` and the off override are combinational and are checked in the same cycle as their inputs. `slot_o` and mode transitions are due one edge after their cause. A comparator change reaches the mode three edges later. A probe resolves PROBE_CLKS edges after it is entered, and a step waits for the next tick. The bench drives inputs on falling edges and compares every output on the following falling edge. The comparison is made against a cycle model built from the requirements, and directed sequences pin the exact edge of each latency.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_CHARGE = 2'd1,
    MODE_SLOW   = 2'd2,
    MODE_FAST   = 2'd3
  } bridge_mode_e;

  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_SLOW   = 2'd1,
    ST_FAST   = 2'd2,
    ST_PROBE  = 2'd3
  } chop_st_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int SLOTS = 4,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          step_i,
  output logic [SW-1:0] slot_o,
  output logic          start_o,
  output logic          restart_o
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;
  logic          pend_q;

  assign restart_o = tick_i & (pend_q | step_i);
  assign start_o   = restart_o | (tick_i & (slot_q == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (start_o)     slot_q <= '0;
      else if (tick_i) slot_q <= slot_q + 1'b1;
      if (restart_o)   pend_q <= 1'b0;
      else if (step_i) pend_q <= 1'b1;
    end
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/torque_scale.sv
module torque_scale #(
  parameter int MAG_W = 10
) (
  input  logic [MAG_W-1:0] mag_i,
  input  logic [1:0]       sel_i,
  output logic [MAG_W-1:0] setpt_o
);
  localparam int PW = MAG_W + 7;

  logic [6:0]    k;
  logic [PW-1:0] prod;

  always_comb begin
    unique case (sel_i)
      2'd0: k = 7'd64;
      2'd1: k = 7'd48;
      2'd2: k = 7'd32;
      default: k = 7'd13;
    endcase
  end

  assign prod    = PW'(mag_i) * PW'(k);
  assign setpt_o = prod[PW-2:6];
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int PROBE_CLKS = 3,
  parameter int BLANK_CLKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       restart_i,
  input  logic [1:0] slot_i,
  input  logic       reach_i,
  input  logic [1:0] decay_sel_i,
  output chop_st_e   st_o
);
  localparam int BW = $clog2(BLANK_CLKS + 1);
  localparam int PW = $clog2(PROBE_CLKS + 1);
  localparam logic [BW-1:0] BLANK_LIM = BW'(BLANK_CLKS);
  localparam logic [PW-1:0] PROBE_LIM = PW'(PROBE_CLKS - 1);

  chop_st_e      st_q, st_d;
  logic [BW-1:0] blank_q, blank_d;
  logic [PW-1:0] probe_q, probe_d;
  logic          fast_en;
  chop_st_e      decay_st;

  // fast window sits in the period tail
  always_comb begin
    unique case (decay_sel_i)
      2'd0: fast_en = 1'b0;
      2'd1: fast_en = (slot_i == 2'd3);
      2'd2: fast_en = slot_i[1];
      default: fast_en = 1'b1;
    endcase
  end

  assign decay_st = fast_en ? ST_FAST : ST_SLOW;

  always_comb begin
    st_d    = st_q;
    blank_d = blank_q;
    probe_d = probe_q;
    if (start_i) begin
      if (restart_i || reach_i) begin
        st_d    = ST_PROBE;
        probe_d = '0;
      end else begin
        st_d    = ST_CHARGE;
        blank_d = '0;
      end
    end else begin
      unique case (st_q)
        ST_CHARGE: begin
          if (blank_q != BLANK_LIM) blank_d = blank_q + 1'b1;
          else if (reach_i)         st_d = decay_st;
        end
        ST_SLOW: if (fast_en) st_d = ST_FAST;
        ST_FAST: ;
        default: begin
          if (probe_q != PROBE_LIM) probe_d = probe_q + 1'b1;
          else if (reach_i)         st_d = decay_st;
          else begin
            st_d    = ST_CHARGE;
            blank_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_CHARGE;
      blank_q <= '0;
      probe_q <= '0;
    end else begin
      st_q    <= st_d;
      blank_q <= blank_d;
      probe_q <= probe_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int MAG_W      = 10,
  parameter int PROBE_CLKS = 3,
  parameter int BLANK_CLKS = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             step_i,
  input  logic             cmp_i,
  input  logic [1:0]       decay_sel_i,
  input  logic [1:0]       torque_sel_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0] setpt_o,
  output logic [1:0]       mode_o,
  output logic [1:0]       slot_o
);
  logic     reach_s, start, restart;
  chop_st_e st;

  cmp_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_i), .q_o(reach_s)
  );

  chop_timer #(.SLOTS(4)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(osc_tick_i), .step_i(step_i),
    .slot_o(slot_o), .start_o(start), .restart_o(restart)
  );

  torque_scale #(.MAG_W(MAG_W)) u_scale (
    .mag_i(mag_i), .sel_i(torque_sel_i), .setpt_o(setpt_o)
  );

  chop_fsm #(.PROBE_CLKS(PROBE_CLKS), .BLANK_CLKS(BLANK_CLKS)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .restart_i(restart),
    .slot_i(slot_o), .reach_i(reach_s), .decay_sel_i(decay_sel_i), .st_o(st)
  );

  bridge_mode_e mode;
  always_comb begin
    if (mag_i == '0) mode = MODE_OFF;
    else begin
      unique case (st)
        ST_SLOW: mode = MODE_SLOW;
        ST_FAST: mode = MODE_FAST;
        default: mode = MODE_CHARGE;
      endcase
    end
  end
  assign mode_o = mode;
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
  parameter int MAG_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             osc_tick_i,
  input logic             step_i,
  input logic [1:0]       decay_sel_i,
  input logic [MAG_W-1:0] mag_i,
  input logic [1:0]       mode_o,
  input logic [1:0]       slot_o
);
  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_tick_i |=> $stable(slot_o));

  p_tick_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_tick_i && slot_o != 2'd3) |=> (slot_o == $past(slot_o) + 2'd1 || slot_o == 2'd0));

  p_fast_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && !osc_tick_i) |=> (mode_o == 2'd3 || mode_o == 2'd0));

  p_slow_from_charge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2 && $past(mode_o) != 2'd0)
      |-> $past(mode_o) == 2'd1);

  p_full_no_slow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decay_sel_i == 2'd3 && $past(decay_sel_i) == 2'd3 && $past(mode_o) != 2'd2)
      |-> mode_o != 2'd2);

  p_step_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && osc_tick_i) |=> slot_o == 2'd0);
endmodule

bind chop_ctrl chop_ctrl_chk #(.MAG_W(MAG_W)) u_chk (.*);

// File: tb/tb_chop_ctrl.sv
`timescale 1ns/1ps
module tb_chop_ctrl;
  localparam int MAG_W = 10;
  localparam int PROBE = 3;
  localparam int BLANK = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, step = 0, cmp = 0;
  logic [1:0] dcy = 0, tq = 0;
  logic [MAG_W-1:0] mag = 10'd100;
  logic [MAG_W-1:0] setpt;
  logic [1:0] mode, slot;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chop_ctrl #(.MAG_W(MAG_W), .PROBE_CLKS(PROBE), .BLANK_CLKS(BLANK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .step_i(step), .cmp_i(cmp),
    .decay_sel_i(dcy), .torque_sel_i(tq), .mag_i(mag),
    .setpt_o(setpt), .mode_o(mode), .slot_o(slot)
  );

  // reference model from the requirements (0 charge, 1 slow, 2 fast, 3 probe)
  logic m_s1, m_s2, m_pend;
  logic [1:0] m_slot;
  int m_st, m_blank, m_probe;

  function automatic bit in_win(logic [1:0] d, logic [1:0] s);
    return d == 3 || (d == 2 && s >= 2) || (d == 1 && s == 3);
  endfunction

  function automatic logic [MAG_W-1:0] exp_setpt(logic [MAG_W-1:0] m, logic [1:0] t);
    int k;
    k = (t == 0) ? 64 : (t == 1) ? 48 : (t == 2) ? 32 : 13;
    return MAG_W'((int'(m) * k) / 64);
  endfunction

  function automatic logic [1:0] exp_mode(int st, logic [MAG_W-1:0] m);
    if (m == 0) return 2'd0;
    return (st == 1) ? 2'd2 : (st == 2) ? 2'd3 : 2'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_pend <= 0; m_slot <= 0;
      m_st <= 0; m_blank <= 0; m_probe <= 0;
    end else begin
      automatic bit rs = tick && (m_pend || step);
      automatic bit ps = rs || (tick && m_slot == 3);
      automatic int nst = m_st, nb = m_blank, np = m_probe;
      automatic int dst = in_win(dcy, m_slot) ? 2 : 1;
      if (ps) begin
        if (rs || m_s2) begin nst = 3; np = 0; end
        else begin nst = 0; nb = 0; end
      end else if (m_st == 0) begin
        if (m_blank < BLANK) nb = m_blank + 1;
        else if (m_s2) nst = dst;
      end else if (m_st == 1) begin
        if (in_win(dcy, m_slot)) nst = 2;
      end else if (m_st == 3) begin
        if (m_probe < PROBE - 1) np = m_probe + 1;
        else if (m_s2) nst = dst;
        else begin nst = 0; nb = 0; end
      end
      m_s1 <= cmp; m_s2 <= m_s1;
      m_slot <= ps ? 2'd0 : (tick ? m_slot + 2'd1 : m_slot);
      m_pend <= rs ? 1'b0 : (step ? 1'b1 : m_pend);
      m_st <= nst; m_blank <= nb; m_probe <= np;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  function automatic string mode_tag();
    if (mag == 0) return "R9";
    if (m_st == 0 && m_blank < BLANK) return "R4";
    if (m_st == 3) return "R7";
    if (m_st == 2 && dcy == 3) return "R6";
    return "R5";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", mode, 1);
    check("R1 slot", slot, 0);
    // R3 set point scaling
    mag = 10'd200;
    tq = 0; #1 check("R3 100%", setpt, 200);
    tq = 1; #1 check("R3 75%", setpt, 150);
    tq = 2; #1 check("R3 50%", setpt, 100);
    tq = 3; #1 check("R3 20%", setpt, 40);
    tq = 0; mag = 10'd100;
    repeat (5) @(negedge clk);
    // R4 synchronizer latency: effect at third edge
    cmp = 1;
    @(negedge clk);
    @(negedge clk); check("R4 still charge", mode, 1);
    @(negedge clk); check("R4 slow after sync", mode, 2);
    // R5 slow to fast at slot 3 for decay select 1
    dcy = 1;
    repeat (3) pulse_tick();
    check("R2 slot 3", slot, 3);
    check("R5 slow before window", mode, 2);
    @(negedge clk); check("R5 fast in window", mode, 3);
    // R7 probe on period start with current above
    pulse_tick();
    check("R7 probe charge", mode, 1);
    check("R2 wrap", slot, 0);
    @(negedge clk);
    @(negedge clk); check("R7 probe last clock", mode, 1);
    @(negedge clk); check("R7 probe resolves to slow", mode, 2);
    // R8 step waits for tick then restarts
    pulse_tick();
    step = 1; @(negedge clk); step = 0;
    @(negedge clk);
    check("R8 no effect before tick", mode, 2);
    check("R8 slot kept", slot, 1);
    pulse_tick();
    check("R8 slot restart", slot, 0);
    check("R8 probe", mode, 1);
    repeat (3) @(negedge clk);
    check("R7 back to slow", mode, 2);
    // R6 full fast decay
    dcy = 3; @(negedge clk);
    check("R6 fast", mode, 3);
    // R9 zero magnitude
    mag = 0; #1 check("R9 off", mode, 0);
    check("R9 setpt", setpt, 0);
    mag = 10'd100;
    @(negedge clk);

    // random phase against the model
    for (int i = 0; i < 20000; i++) begin
      check(mode_tag(), mode, exp_mode(m_st, mag));
      check("R2 slot", slot, m_slot);
      check("R3 setpt", setpt, exp_setpt(mag, tq));
      tick = ($urandom % 11 == 0);
      step = ($urandom % 97 == 0);
      if ($urandom % 9 == 0) cmp = ~cmp;
      if ($urandom % 150 == 0) dcy = 2'($urandom);
      if ($urandom % 150 == 0) tq = 2'($urandom);
      if ($urandom % 60 == 0) mag = ($urandom % 8 == 0) ? '0 : MAG_W'($urandom);
      @(negedge clk);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule